// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the SD card clock from the fixed base clock it runs on. The division is done in two stages: a prescale code P and a linear divisor code D. Together they give a card clock of base / ((P*2) * (D+1)), with a 50% duty cycle. The codes come from one of two places. A caller can write them directly, or a small search engine can pick them for a requested target frequency. The engine works one step per cycle. It first looks for a power-of-two prescaler and then for the smallest linear divisor that brings the card clock to or below the target.

The card clock toggles only while the enable input is high. A one-cycle init request starts a power-up burst of 80 card clock cycles, and a busy flag stays high for the whole burst and then drops by itself. A soft reset request clears the divider state, and its own busy flag stays high until the clear is complete. New codes never cut a high phase short. The divider picks them up only at the start of a low phase.

Top module: `sdclk_divider`

## Requirements
- R1: Half-period length. With codes P and D, each high phase and each low phase of `card_clk` lasts max(P,1)*(D+1) base clock cycles. A P of 0 is treated as 1.
- R2: Clock enable.
  - When `clk_en` is low at a clock edge, `card_clk` is low from that edge on.
  - When `clk_en` rises again, the first phase is a complete low phase.
- R3: Code write.
  - A `code_wr` pulse loads `presc_in` and `div_in` into `presc_code` and `div_code` at the next edge.
  - A high phase that is already running keeps its old length. The new length applies from the next low phase.
- R4: Prescaler search.
  - A `search_start` pulse latches `target_khz`. The base frequency in kHz is BASE_KHZ, 100000 by default.
  - If floor(base/16) > target, the prescaler p is the first value of 2, 4, ..., 128 for which floor(base/p) <= 16*target. If none of these values qualifies, p is 256.
  - In every other case, p is 2.
- R5: Divisor search.
  - The divisor d is the first value of 1..16 for which floor(base/(d*p)) <= target.
  - If no value in that range qualifies, d is 17.
- R6: Search result and busy.
  - When the search ends, `presc_code` becomes p/2 and `div_code` becomes d-1.
  - `search_busy` is high from the edge after the start until the codes are loaded.
  - A `code_wr` while `search_busy` is high has no effect.
- R7: Init burst.
  - An `init_req` sets `init_busy` at the next edge.
  - `init_busy` stays high through 80 rising edges of `card_clk` and falls at the same edge as the 80th rise.
  - An `init_req` during a burst neither restarts nor extends it.
- R8: While `clk_en` is low, a burst in progress stalls. `init_busy` stays high and the remaining rises are sent after the clock is enabled again.
- R9: Soft reset.
  - A `soft_rst` pulse makes `rst_busy` high for 4 cycles (RST_CYCLES), starting at the next edge.
  - At its end, `presc_code` and `div_code` are 0, `card_clk` is low, `init_busy` is low and any search is aborted, so `search_busy` is low.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| soft_rst | input | 1 | Pulse: request a controller-wide clear |
| search_start | input | 1 | Pulse: start a code search for `target_khz` |
| target_khz | input | 32 | Target card clock in kHz |
| code_wr | input | 1 | Pulse: load codes directly |
| presc_in | input | 8 | Prescale code for a direct load |
| div_in | input | 5 | Divisor code for a direct load |
| clk_en | input | 1 | Card clock enable |
| init_req | input | 1 | Pulse: start the 80-cycle power-up burst |
| card_clk | output | 1 | Divided card clock |
| init_busy | output | 1 | High while the burst runs |
| rst_busy | output | 1 | High while the soft reset runs |
| search_busy | output | 1 | High while the search engine works |
| presc_code | output | 8 | Stored prescale code |
| div_code | output | 5 | Stored divisor code |

## Verification
A wrong search state shows up in `presc_code` and `div_code` as soon as `search_busy` drops. The target vectors therefore sit on both sides of every loop boundary, including the two fallback cases of 256 and 17. A stale or early-loaded half-period count shows up in the very next high or low phase of `card_clk`, which the bench measures cycle by cycle. A burst counter that is off by one moves the edge where `init_busy` falls by one card clock rise.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  parameter int PRESC_W = 8;
  parameter int DIV_W   = 5;
  parameter int CALC_W  = 48;

  localparam int HALF_W = PRESC_W + DIV_W;
  localparam int PLOG_W = $clog2(PRESC_W + 1);

  typedef logic [CALC_W-1:0] calc_t;

  typedef enum logic [1:0] {
    SR_IDLE,
    SR_PRE,
    SR_DIV
  } srch_state_e;

  // Number of base cycles in one card clock phase.
  function automatic logic [HALF_W-1:0] half_len(input logic [PRESC_W-1:0] p,
                                                 input logic [DIV_W-1:0] d);
    logic [HALF_W-1:0] pe;
    logic [HALF_W-1:0] de;
    pe = (p == '0) ? HALF_W'(1) : HALF_W'(p);
    de = HALF_W'(d) + HALF_W'(1);
    return pe * de;
  endfunction

  // floor(base/16) > target
  function automatic logic need_pre(input calc_t base, input calc_t tgt);
    return (base >> 4) > tgt;
  endfunction

  // floor(base/2^plog) <= 16*target
  function automatic logic pre_stop(input calc_t base, input calc_t tgt,
                                    input logic [PLOG_W-1:0] plog);
    return (base >> plog) <= (tgt << 4);
  endfunction

  // floor(base/(d*2^plog)) <= target, written as base < (target+1)*d*2^plog
  function automatic logic div_ok(input calc_t base, input calc_t tgt,
                                  input logic [DIV_W:0] d,
                                  input logic [PLOG_W-1:0] plog);
    return base < (((tgt + calc_t'(1)) * calc_t'(d)) << plog);
  endfunction

endpackage

// File: rtl/sdclk_search.sv
module sdclk_search import sdclk_pkg::*; #(
  parameter int unsigned BASE_KHZ = 100000,
  parameter int          TARGET_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                start,
  input  logic [TARGET_W-1:0] target,
  output logic                busy,
  output logic                done,
  output logic [PRESC_W-1:0]  presc_o,
  output logic [DIV_W-1:0]    div_o
);

  localparam int    PLOG_MAX = PRESC_W;
  localparam int    D_LAST   = (1 << (DIV_W - 1)) + 1;
  localparam calc_t BASE     = calc_t'(BASE_KHZ);

  srch_state_e       st;
  calc_t             tgt;
  logic [PLOG_W-1:0] plog;
  logic [DIV_W:0]    dval;
  logic              pre_hit, div_hit, at_pmax, at_dlast;

  always_comb begin
    pre_hit  = pre_stop(BASE, tgt, plog);
    div_hit  = div_ok(BASE, tgt, dval, plog);
    at_pmax  = (plog == PLOG_W'(PLOG_MAX));
    at_dlast = (dval == (DIV_W+1)'(D_LAST));
    done     = (st == SR_DIV) && (at_dlast || div_hit);
    busy     = (st != SR_IDLE);
    presc_o  = PRESC_W'(1) << (plog - PLOG_W'(1));
    div_o    = DIV_W'(dval - (DIV_W+1)'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= SR_IDLE;
      tgt  <= '0;
      plog <= PLOG_W'(1);
      dval <= (DIV_W+1)'(1);
    end else if (clr) begin
      st <= SR_IDLE;
    end else begin
      case (st)
        SR_IDLE: if (start) begin
          tgt  <= calc_t'(target);
          plog <= PLOG_W'(1);
          dval <= (DIV_W+1)'(1);
          st   <= need_pre(BASE, calc_t'(target)) ? SR_PRE : SR_DIV;
        end
        SR_PRE: begin
          if (at_pmax || pre_hit) st <= SR_DIV;
          else                    plog <= plog + PLOG_W'(1);
        end
        SR_DIV: begin
          if (done) st <= SR_IDLE;
          else      dval <= dval + (DIV_W+1)'(1);
        end
        default: st <= SR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen import sdclk_pkg::*; #(
  parameter int INIT_EDGES = 80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               en,
  input  logic [PRESC_W-1:0] presc,
  input  logic [DIV_W-1:0]   div,
  input  logic               init_req,
  output logic               card_clk,
  output logic               init_busy,
  output logic [HALF_W-1:0]  half_act
);

  localparam int EW = $clog2(INIT_EDGES + 1);

  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] half_new;
  logic              clk_q, phase_end, rise_ev;
  logic [EW-1:0]     edges;

  assign half_new  = half_len(presc, div);
  assign phase_end = (cnt == half_act - HALF_W'(1));
  assign rise_ev   = en & ~clk_q & phase_end;
  assign card_clk  = clk_q;

  // Phase counter; a new phase length is picked up only when a low phase begins.
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt      <= '0;
      clk_q    <= 1'b0;
      half_act <= HALF_W'(1);
    end else if (!en) begin
      cnt      <= '0;
      clk_q    <= 1'b0;
      half_act <= half_new;
    end else if (phase_end) begin
      cnt   <= '0;
      clk_q <= ~clk_q;
      if (clk_q) half_act <= half_new;
    end else begin
      cnt <= cnt + HALF_W'(1);
    end
  end

  // Power-up burst: counts card clock rises, clears itself on the last one.
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      init_busy <= 1'b0;
      edges     <= '0;
    end else if (!init_busy) begin
      if (init_req) begin
        init_busy <= 1'b1;
        edges     <= '0;
      end
    end else if (rise_ev) begin
      if (edges == EW'(INIT_EDGES - 1)) begin
        init_busy <= 1'b0;
        edges     <= '0;
      end else begin
        edges <= edges + EW'(1);
      end
    end
  end

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider import sdclk_pkg::*; #(
  parameter int unsigned BASE_KHZ   = 100000,
  parameter int          TARGET_W   = 32,
  parameter int          INIT_EDGES = 80,
  parameter int          RST_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                search_start,
  input  logic [TARGET_W-1:0] target_khz,
  input  logic                code_wr,
  input  logic [PRESC_W-1:0]  presc_in,
  input  logic [DIV_W-1:0]    div_in,
  input  logic                clk_en,
  input  logic                init_req,
  output logic                card_clk,
  output logic                init_busy,
  output logic                rst_busy,
  output logic                search_busy,
  output logic [PRESC_W-1:0]  presc_code,
  output logic [DIV_W-1:0]    div_code
);

  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic [RC_W-1:0]    rst_cnt;
  logic               srch_done;
  logic [PRESC_W-1:0] srch_presc;
  logic [DIV_W-1:0]   srch_div;
  logic [HALF_W-1:0]  half_act;

  assign rst_busy = (rst_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        rst_cnt <= '0;
    else if (rst_busy) rst_cnt <= rst_cnt - RC_W'(1);
    else if (soft_rst) rst_cnt <= RC_W'(RST_CYCLES);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rst_busy) begin
      presc_code <= '0;
      div_code   <= '0;
    end else if (srch_done) begin
      presc_code <= srch_presc;
      div_code   <= srch_div;
    end else if (code_wr && !search_busy) begin
      presc_code <= presc_in;
      div_code   <= div_in;
    end
  end

  sdclk_search #(
    .BASE_KHZ (BASE_KHZ),
    .TARGET_W (TARGET_W)
  ) u_search (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (rst_busy),
    .start   (search_start),
    .target  (target_khz),
    .busy    (search_busy),
    .done    (srch_done),
    .presc_o (srch_presc),
    .div_o   (srch_div)
  );

  sdclk_gen #(
    .INIT_EDGES (INIT_EDGES)
  ) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rst_busy),
    .en        (clk_en),
    .presc     (presc_code),
    .div       (div_code),
    .init_req  (init_req),
    .card_clk  (card_clk),
    .init_busy (init_busy),
    .half_act  (half_act)
  );

endmodule

// File: rtl/sdclk_divider_chk.sv
module sdclk_divider_chk import sdclk_pkg::*; (
  input logic               clk,
  input logic               rst_n,
  input logic               soft_rst,
  input logic               code_wr,
  input logic               clk_en,
  input logic               init_req,
  input logic               card_clk,
  input logic               init_busy,
  input logic               rst_busy,
  input logic               search_busy,
  input logic [PRESC_W-1:0] presc_code,
  input logic [DIV_W-1:0]   div_code,
  input logic [HALF_W-1:0]  half_act
);

  p_gate_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> !card_clk);

  p_high_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (card_clk && $past(card_clk)) |-> $stable(half_act));

  p_codes_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_wr && !search_busy && !rst_busy) |=> ($stable(presc_code) && $stable(div_code)));

  p_init_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_busy) |-> $past(init_req));

  p_init_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (init_busy && !clk_en && !rst_busy) |=> init_busy);

  p_rst_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !rst_busy) |=> rst_busy);

  p_rst_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |=> (presc_code == '0 && div_code == '0 && !card_clk && !init_busy && !search_busy));

endmodule

bind sdclk_divider sdclk_divider_chk u_chk (.*);

// File: tb/sdclk_divider_tb.sv
`timescale 1ns/1ps
module sdclk_divider_tb;
  import sdclk_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n = 1'b0;
  logic               soft_rst = 1'b0;
  logic               search_start = 1'b0;
  logic [31:0]        target_khz = '0;
  logic               code_wr = 1'b0;
  logic [PRESC_W-1:0] presc_in = '0;
  logic [DIV_W-1:0]   div_in = '0;
  logic               clk_en = 1'b0;
  logic               init_req = 1'b0;
  logic               card_clk, init_busy, rst_busy, search_busy;
  logic [PRESC_W-1:0] presc_code;
  logic [DIV_W-1:0]   div_code;

  int checks = 0;
  int fails  = 0;

  sdclk_divider u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .search_start(search_start),
    .target_khz(target_khz), .code_wr(code_wr), .presc_in(presc_in), .div_in(div_in),
    .clk_en(clk_en), .init_req(init_req), .card_clk(card_clk), .init_busy(init_busy),
    .rst_busy(rst_busy), .search_busy(search_busy), .presc_code(presc_code),
    .div_code(div_code)
  );

  // target kHz -> expected prescale code, divisor code (base 100000 kHz)
  localparam int NV = 10;
  localparam int unsigned V_T [NV] = '{400, 25000, 50000, 100000, 0, 1000, 6250, 6249, 100, 10};
  localparam int unsigned V_P [NV] = '{8,   1,     1,     1,      128, 4,  1,    1,    32,  128};
  localparam int unsigned V_D [NV] = '{15,  1,     0,     0,      16,  12, 7,    8,    15,  16};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic prev;
    bit   seen;
    prev = card_clk;
    seen = 1'b0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      if (card_clk && !prev) seen = 1'b1;
      prev = card_clk;
    end
    if (!seen) chk("R1 card_clk rise timeout", 0, 1);
  endtask

  task automatic measure(input string req, input int exp_half);
    int hi, lo;
    wait_rise();
    hi = 0;
    do begin hi++; @(negedge clk); end while (card_clk && hi < 5000);
    lo = 0;
    do begin lo++; @(negedge clk); end while (!card_clk && lo < 5000);
    chk({req, " high phase"}, hi, exp_half);
    chk({req, " low phase"}, lo, exp_half);
  endtask

  task automatic write_codes(input int p, input int d);
    @(negedge clk);
    code_wr  = 1'b1;
    presc_in = PRESC_W'(p);
    div_in   = DIV_W'(d);
    @(negedge clk);
    code_wr  = 1'b0;
  endtask

  task automatic run_search(input int unsigned t);
    @(negedge clk);
    search_start = 1'b1;
    target_khz   = t;
    @(negedge clk);
    search_start = 1'b0;
    for (int i = 0; i < 200 && search_busy; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int hi, lo, rises, stall_bad, hits;
    logic prev;
    bit stalled, repulsed;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 card_clk", int'(card_clk), 0);
    chk("R10 init_busy", int'(init_busy), 0);
    chk("R10 rst_busy", int'(rst_busy), 0);
    chk("R10 search_busy", int'(search_busy), 0);
    chk("R10 presc_code", int'(presc_code), 0);
    chk("R10 div_code", int'(div_code), 0);
    rst_n = 1'b1;

    // R4 R5 R6: search vectors
    for (int v = 0; v < NV; v++) begin
      run_search(V_T[v]);
      chk($sformatf("R4 R6 presc for target %0d", V_T[v]), int'(presc_code), int'(V_P[v]));
      chk($sformatf("R5 R6 div for target %0d", V_T[v]), int'(div_code), int'(V_D[v]));
    end

    // R6: direct write ignored while the search runs
    @(negedge clk);
    search_start = 1'b1;
    target_khz   = 400;
    @(negedge clk);
    search_start = 1'b0;
    code_wr = 1'b1; presc_in = 8'd5; div_in = 5'd5;
    @(negedge clk);
    code_wr = 1'b0;
    for (int i = 0; i < 200 && search_busy; i++) @(negedge clk);
    chk("R6 write ignored presc", int'(presc_code), 8);
    chk("R6 write ignored div", int'(div_code), 15);

    // R1: period from direct codes
    clk_en = 1'b1;
    write_codes(1, 0); wait_rise(); measure("R1 P1 D0", 1);
    write_codes(0, 2); wait_rise(); measure("R1 P0 D2", 3);
    write_codes(3, 1); wait_rise(); measure("R1 P3 D1", 6);
    write_codes(2, 4); wait_rise(); measure("R1 P2 D4", 10);
    chk("R3 code_wr loads presc", int'(presc_code), 2);
    chk("R3 code_wr loads div", int'(div_code), 4);

    // R3: write during high phase keeps its length
    write_codes(0, 9); wait_rise(); measure("R3 settle", 10);
    wait_rise();
    code_wr = 1'b1; presc_in = 8'd0; div_in = 5'd1;
    hi = 0;
    do begin hi++; @(negedge clk); code_wr = 1'b0; end while (card_clk && hi < 100);
    lo = 0;
    do begin lo++; @(negedge clk); end while (!card_clk && lo < 100);
    chk("R3 running high phase keeps old length", hi, 10);
    chk("R3 next low phase uses new length", lo, 2);

    // R2: gating and restart with a full low phase
    @(negedge clk);
    clk_en = 1'b0;
    hits = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (card_clk) hits++;
    end
    chk("R2 card_clk held low while disabled", hits, 0);
    clk_en = 1'b1;
    lo = 0;
    do begin @(negedge clk); lo++; end while (!card_clk && lo < 100);
    chk("R2 first low phase after enable", lo, 2);

    // R7 R8: init burst with a stall and an ignored re-request
    write_codes(1, 0);
    wait_rise(); wait_rise();
    @(negedge clk);
    init_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    init_req = 1'b0;
    chk("R7 init_busy set after request", int'(init_busy), 1);
    prev = card_clk;
    rises = 0; stalled = 1'b0; repulsed = 1'b0; stall_bad = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      init_req = 1'b0;
      if (card_clk && !prev) rises++;
      prev = card_clk;
      if (!init_busy) break;
      if (rises == 40 && !repulsed) begin
        repulsed = 1'b1;
        init_req = 1'b1;
      end
      if (rises == 20 && !stalled) begin
        stalled = 1'b1;
        clk_en = 1'b0;
        for (int k = 0; k < 30; k++) begin
          @(negedge clk);
          if (!init_busy || card_clk) stall_bad++;
        end
        clk_en = 1'b1;
        prev = card_clk;
      end
    end
    chk("R8 busy held and clock low during stall", stall_bad, 0);
    chk("R7 rises until init_busy falls", rises, 80);
    chk("R7 init_busy cleared", int'(init_busy), 0);

    // R9: soft reset clears codes and aborts a search
    write_codes(3, 3);
    @(negedge clk);
    search_start = 1'b1;
    target_khz   = 0;
    @(negedge clk);
    search_start = 1'b0;
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    hits = 0;
    while (rst_busy && hits < 100) begin hits++; @(negedge clk); end
    chk("R9 rst_busy length", hits, 4);
    chk("R9 presc cleared", int'(presc_code), 0);
    chk("R9 div cleared", int'(div_code), 0);
    chk("R9 search aborted", int'(search_busy), 0);
    chk("R9 init_busy low", int'(init_busy), 0);
    clk_en = 1'b0;
    @(negedge clk);
    chk("R9 card_clk low", int'(card_clk), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule